// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Parallel Bus

The block is an eight-bit register with four operations, chosen by a two-bit mode field: keep its contents, shift toward the high bit, shift toward the low bit, or take a word from the parallel bus. Every change of state happens on the rising clock edge. The only exception is the asynchronous active-low clear, which empties the register at once and keeps it empty for as long as it is held.

One set of parallel pins carries load data into the register and also presents the stored word. For synthesis this bus is split into an input word, an output word and a single drive-enable. The register drives the bus only when both active-low output enables are low and the mode is not load. The bus is therefore free to carry load data with no contention. The lowest and highest bits also have their own serial outputs. These are always driven, so several registers can be chained through the serial inputs.

Top module: `usr_shift_reg`

## Requirements
- R1: While `rst_n` is low, the register reads zero. It clears as soon as `rst_n` falls, without waiting for a clock edge, and it stays zero across clock edges in any mode.
- R2: With `mode` = 2'b00 (hold), the register keeps its value across a rising clock edge.
- R3: With `mode` = 2'b01 (shift up), every bit i moves to bit i+1 on the rising edge and `ser_in_up` enters bit 0.
- R4: With `mode` = 2'b10 (shift down), every bit i moves to bit i-1 on the rising edge and `ser_in_down` enters bit 7.
- R5: With `mode` = 2'b11 (load), the register takes `bus_in` on the rising edge.
- R6: `bus_drive` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode` is not 2'b11. This follows the inputs without waiting for a clock edge.
- R7: `bus_out` always presents the current register contents.
- R8: `ser_out_lo` equals bit 0 and `ser_out_hi` equals bit 7 of the register, whatever the output enables are.
- R9: The serial inputs have no effect in hold and load modes, and `bus_in` has no effect in any mode other than load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial bit entering bit 0 when shifting up |
| ser_in_down | input | 1 | Serial bit entering bit 7 when shifting down |
| oe_a_n | input | 1 | First bus output enable, active low |
| oe_b_n | input | 1 | Second bus output enable, active low |
| bus_in | input | 8 | Word seen on the shared parallel bus |
| bus_out | output | 8 | Register contents offered to the shared bus |
| bus_drive | output | 1 | High when the register drives the shared bus |
| ser_out_lo | output | 1 | Bit 0, always driven |
| ser_out_hi | output | 1 | Bit 7, always driven |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a parallel load and bus driving, when load mode is selected while both enables are low. The second pair is the asynchronous clear and a clock edge that would otherwise load or shift. The bench provokes the first pair with random mixes of mode and enables and with a directed case of load under full enable. It judges `bus_drive` before the edge and the loaded word after it. For the second pair it lowers `rst_n` between edges, with a nonzero word held and load selected. It expects zero before the next edge and zero again after it.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
`timescale 1ns/1ps
module usr_next_state
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  usr_mode_e        mode,
  input  logic             ser_up,
  input  logic             ser_down,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] from_below;
  logic [WIDTH-1:0] from_above;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_low
      assign from_below[i] = ser_up;
    end else begin : g_low_mid
      assign from_below[i] = cur[i-1];
    end
    if (i == TOP) begin : g_high
      assign from_above[i] = ser_down;
    end else begin : g_high_mid
      assign from_above[i] = cur[i+1];
    end
  end

  always_comb begin
    unique case (mode)
      MODE_UP:   nxt = from_below;
      MODE_DOWN: nxt = from_above;
      MODE_LOAD: nxt = par_in;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/usr_drive_ctrl.sv
`timescale 1ns/1ps
module usr_drive_ctrl #(
  parameter int N_OE = 2
) (
  input  logic [N_OE-1:0] oe_n,
  input  logic            load_sel,
  output logic            drive
);
  assign drive = ~(|oe_n) & ~load_sel;
endmodule

// File: rtl/usr_state_reg.sv
`timescale 1ns/1ps
module usr_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/usr_shift_reg.sv
`timescale 1ns/1ps
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ser_in_up,
  input  logic             ser_in_down,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drive,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode_e;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  assign mode_e = usr_mode_e'(mode);

  usr_next_state #(.WIDTH(WIDTH)) next_i (
    .cur      (state_q),
    .mode     (mode_e),
    .ser_up   (ser_in_up),
    .ser_down (ser_in_down),
    .par_in   (bus_in),
    .nxt      (state_d)
  );

  usr_state_reg #(.WIDTH(WIDTH)) reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (state_d),
    .q     (state_q)
  );

  usr_drive_ctrl #(.N_OE(2)) drv_i (
    .oe_n     ({oe_b_n, oe_a_n}),
    .load_sel (mode_e == MODE_LOAD),
    .drive    (bus_drive)
  );

  assign bus_out    = state_q;
  assign ser_out_lo = state_q[0];
  assign ser_out_hi = state_q[TOP];
endmodule

// File: rtl/usr_shift_reg_chk.sv
`timescale 1ns/1ps
module usr_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             ser_in_up,
  input logic             ser_in_down,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_drive,
  input logic             ser_out_lo,
  input logic             ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  p_clear_r1: assert property (@(posedge clk) !rst_n |-> bus_out == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> $stable(bus_out));

  p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> bus_out == {$past(bus_out[TOP-1:0]), $past(ser_in_up)});

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> bus_out == {$past(ser_in_down), $past(bus_out[TOP:1])});

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> bus_out == $past(bus_in));

  p_no_drive_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> !bus_drive);

  p_drive_needs_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (!oe_a_n && !oe_b_n));

  p_serial_taps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_lo == bus_out[0] && ser_out_hi == bus_out[TOP]);
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/usr_shift_reg_tb.sv
`timescale 1ns/1ps
module usr_shift_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode = 2'b00;
  logic         ser_in_up = 1'b0;
  logic         ser_in_down = 1'b0;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_drive;
  logic         ser_out_lo;
  logic         ser_out_hi;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usr_shift_reg #(.WIDTH(W)) dut_i (.*);

  function automatic logic [W-1:0] next_word(logic [W-1:0] cur, logic [1:0] m,
                                             logic su, logic sd, logic [W-1:0] bi);
    case (m)
      2'b01:   return {cur[W-2:0], su};
      2'b10:   return {sd, cur[W-1:1]};
      2'b11:   return bi;
      default: return cur;
    endcase
  endfunction

  function automatic logic exp_drive(logic [1:0] m, logic a, logic b);
    return (a == 1'b0) && (b == 1'b0) && (m != 2'b11);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'b00:   return "R2 hold";
      2'b01:   return "R3 shift up";
      2'b10:   return "R4 shift down";
      default: return "R5 load";
    endcase
  endfunction

  // Called just after a falling edge.
  task automatic apply(logic [1:0] m, logic su, logic sd, logic [W-1:0] bi,
                       logic a, logic b);
    mode = m; ser_in_up = su; ser_in_down = sd; bus_in = bi;
    oe_a_n = a; oe_b_n = b;
    #1;
    check("R6 bus_drive", {7'b0, bus_drive}, {7'b0, exp_drive(m, a, b)});
    @(posedge clk);
    model = next_word(model, m, su, sd, bi);
    @(negedge clk);
    check(mode_req(m), bus_out, model);
    check("R7/R8 serial taps", {6'b0, ser_out_hi, ser_out_lo},
          {6'b0, model[W-1], model[0]});
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", bus_out, '0);
    check("R1 reset taps", {6'b0, ser_out_hi, ser_out_lo}, '0);
    rst_n = 1'b1;
    model = '0;

    // R5 load with enables asserted: no drive during load
    apply(2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0);
    // R6 drive when both enables low and not loading
    apply(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    apply(2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    apply(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    // R9 hold ignores serial inputs and bus
    apply(2'b00, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1);
    check("R9 hold ignores inputs", bus_out, 8'hA5);
    // R3 fill with ones from the low end
    for (int k = 0; k < W; k++) apply(2'b01, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R3 full fill", bus_out, 8'hFF);
    // R4 fill with zeros from the high end
    for (int k = 0; k < W; k++) apply(2'b10, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
    check("R4/R9 drain ignores bus", bus_out, 8'h00);
    // R9 load ignores serial inputs
    apply(2'b11, 1'b1, 1'b1, 8'h42, 1'b1, 1'b1);
    check("R9 load ignores serial", bus_out, 8'h42);

    // R1 asynchronous clear between edges, then a load edge under reset
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", bus_out, '0);
    mode = 2'b11; bus_in = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    check("R1 held under load", bus_out, '0);
    rst_n = 1'b1;
    model = '0;

    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      apply(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule